// File: doc/BRIEF.md
# Packed Element Register File Port

This block holds a file of XLEN-wide registers and lets a datapath address it as a flat array of bytes that is cut into elements of a chosen width. A caller names a base register, an element index and a width code. The element sits at the first byte of the base register, offset by the index times the element size. Vectors are packed with no padding, so a large index simply walks into later registers.

There is one write port and one read port. A write changes only the bytes of the addressed element. The rest of that register and every other register keep their values. A read returns the element in the cycle after the request, either zero-extended or sign-extended to XLEN as the caller selects. An address that falls past the last byte of the file raises an error flag: the write is dropped, and the read returns zero.

Top module: `pkrf_port`

## Requirements
- R1: The byte address of an element is base_register*(XLEN/8) + index*element_bytes. With XLEN=64 it lies in register address/8 at byte address%8, where byte 0 is bits 7:0.
- R2: Width code 2'b01 selects 1-byte elements, 2'b10 selects 2-byte elements, 2'b11 selects 4-byte elements, and 2'b00 selects XLEN-wide elements.
- R3: An in-range write changes exactly the bytes its element covers. Every other byte of that register and of all other registers is unchanged.
- R4: Bits of wdata_i above the element width have no effect on the file.
- R5: When re_i is high at a rising clock edge, rvalid_o is high for the following cycle and rdata_o holds the element. With rsigned_i low the element is zero-extended. When re_i is low, rvalid_o is low in the following cycle.
- R6: With rsigned_i high, a narrow element is sign-extended from its top bit. An XLEN-wide element reads the same whichever value rsigned_i has.
- R7: When we_i is high and the element address is at or beyond NREGS*(XLEN/8), werr_o is high in that same cycle and no byte of the file changes. werr_o is never high while we_i is low.
- R8: A read whose element address is at or beyond NREGS*(XLEN/8) gives rerr_o high together with rvalid_o, and rdata_o is zero.
- R9: A read and a write to the same bytes in the same cycle: the read returns the contents from before the write.
- R10: After reset every register reads as zero, and rvalid_o, rerr_o and rdata_o are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| we_i | input | 1 | Write request |
| wreg_i | input | 7 | Write base register number |
| widx_i | input | 10 | Write element index |
| wkind_i | input | 2 | Write element width code |
| wdata_i | input | 64 | Write element data, right-aligned |
| werr_o | output | 1 | Write address out of range (combinational) |
| re_i | input | 1 | Read request |
| rreg_i | input | 7 | Read base register number |
| ridx_i | input | 10 | Read element index |
| rkind_i | input | 2 | Read element width code |
| rsigned_i | input | 1 | Sign-extend the read element |
| rvalid_o | output | 1 | Read data valid, one cycle after re_i |
| rerr_o | output | 1 | Read address out of range |
| rdata_o | output | 64 | Extended read element |

## Verification
Some properties are checked on every cycle: the one-cycle relation between re_i and rvalid_o, zero data on a read error, a write error never showing up without a write request, and the shape of the upper bits for zero-extended byte reads and sign-extended halfword reads. The placement of elements cannot be seen by a property on the ports. The bench shows it: elements crossing into later registers, neighbouring bytes kept intact, data above the element width ignored, suppressed out-of-range writes and read-before-write ordering. It does so against a byte-level model, and a sweep of every register at the end exposes any stray byte change.

// File: rtl/pkrf_pkg.sv
package pkrf_pkg;
  typedef enum logic [1:0] {
    EK_FULL = 2'b00,
    EK_B    = 2'b01,
    EK_H    = 2'b10,
    EK_W    = 2'b11
  } elem_kind_e;
endpackage

// File: rtl/pkrf_addr.sv
module pkrf_addr
  import pkrf_pkg::*;
#(
  parameter int unsigned XLEN  = 64,
  parameter int unsigned NREGS = 128,
  parameter int unsigned IDXW  = 10,
  localparam int unsigned BPR  = XLEN / 8,
  localparam int unsigned OFFW = $clog2(BPR),
  localparam int unsigned RW   = $clog2(NREGS),
  localparam int unsigned SHW  = $clog2(OFFW + 1)
) (
  input  logic [RW-1:0]   reg_i,
  input  logic [IDXW-1:0] idx_i,
  input  logic [1:0]      kind_i,
  output logic [RW-1:0]   row_o,
  output logic [OFFW-1:0] off_o,
  output logic [SHW-1:0]  shift_o,
  output logic            err_o
);
  localparam int unsigned BAW   = RW + OFFW;
  localparam int unsigned MW    = (IDXW > BAW) ? IDXW : BAW;
  localparam int unsigned EXTW  = MW + OFFW + 1;
  localparam int unsigned TOTAL = NREGS * BPR;

  logic [SHW-1:0]  shift;
  logic [EXTW-1:0] base_b, scaled, addr;

  always_comb begin
    case (elem_kind_e'(kind_i))
      EK_B:    shift = '0;
      EK_H:    shift = SHW'(1);
      EK_W:    shift = SHW'(2);
      default: shift = SHW'(OFFW);
    endcase
  end

  // wide enough that base + scaled index never wraps
  assign base_b  = EXTW'({reg_i, {OFFW{1'b0}}});
  assign scaled  = EXTW'(idx_i) << shift;
  assign addr    = base_b + scaled;
  assign err_o   = (addr >= EXTW'(TOTAL));
  assign row_o   = addr[BAW-1:OFFW];
  assign off_o   = addr[OFFW-1:0];
  assign shift_o = shift;
endmodule

// File: rtl/pkrf_lane_write.sv
module pkrf_lane_write #(
  parameter int unsigned XLEN = 64,
  localparam int unsigned BPR  = XLEN / 8,
  localparam int unsigned OFFW = $clog2(BPR),
  localparam int unsigned SHW  = $clog2(OFFW + 1)
) (
  input  logic [OFFW-1:0] off_i,
  input  logic [SHW-1:0]  shift_i,
  input  logic [XLEN-1:0] data_i,
  output logic [BPR-1:0]  be_o,
  output logic [XLEN-1:0] word_o
);
  localparam int unsigned EW = OFFW + 1;

  logic [EW-1:0] lo, hi;

  assign lo = {1'b0, off_i};
  assign hi = lo + (EW'(1) << shift_i);

  for (genvar b = 0; b < int'(BPR); b++) begin : g_be
    assign be_o[b] = (EW'(b) >= lo) && (EW'(b) < hi);
  end

  // bytes beyond the element are masked by be_o, so upper data bits drop out
  assign word_o = data_i << {off_i, 3'b000};
endmodule

// File: rtl/pkrf_bank.sv
module pkrf_bank #(
  parameter int unsigned XLEN  = 64,
  parameter int unsigned NREGS = 128,
  localparam int unsigned BPR  = XLEN / 8,
  localparam int unsigned RW   = $clog2(NREGS)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            we_i,
  input  logic [RW-1:0]   wrow_i,
  input  logic [BPR-1:0]  be_i,
  input  logic [XLEN-1:0] wword_i,
  input  logic            re_i,
  input  logic [RW-1:0]   rrow_i,
  output logic [XLEN-1:0] rword_o
);
  logic [XLEN-1:0] mem [NREGS];
  logic [XLEN-1:0] rword_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < int'(NREGS); i++) mem[i] <= '0;
      rword_q <= '0;
    end else begin
      if (we_i) begin
        for (int b = 0; b < int'(BPR); b++) begin
          if (be_i[b]) mem[wrow_i][b*8 +: 8] <= wword_i[b*8 +: 8];
        end
      end
      // old contents are captured when a write hits the same row
      if (re_i) rword_q <= mem[rrow_i];
    end
  end

  assign rword_o = rword_q;
endmodule

// File: rtl/pkrf_extract.sv
module pkrf_extract #(
  parameter int unsigned XLEN = 64,
  localparam int unsigned BPR  = XLEN / 8,
  localparam int unsigned OFFW = $clog2(BPR),
  localparam int unsigned SHW  = $clog2(OFFW + 1)
) (
  input  logic [XLEN-1:0] word_i,
  input  logic [OFFW-1:0] off_i,
  input  logic [SHW-1:0]  shift_i,
  input  logic            signed_i,
  input  logic            err_i,
  output logic [XLEN-1:0] data_o
);
  localparam int unsigned IXW = $clog2(XLEN);
  localparam int unsigned WBW = IXW + 1;

  logic [XLEN-1:0] aligned, ext;
  logic [WBW-1:0]  nbits;
  logic [IXW-1:0]  msb;
  logic            fill;

  assign aligned = word_i >> {off_i, 3'b000};
  assign nbits   = WBW'(8) << shift_i;
  assign msb     = IXW'(nbits - WBW'(1));
  assign fill    = signed_i & aligned[msb];

  for (genvar i = 0; i < int'(XLEN); i++) begin : g_ext
    assign ext[i] = (WBW'(i) < nbits) ? aligned[i] : fill;
  end

  assign data_o = err_i ? '0 : ext;
endmodule

// File: rtl/pkrf_port.sv
module pkrf_port
  import pkrf_pkg::*;
#(
  parameter int unsigned XLEN  = 64,
  parameter int unsigned NREGS = 128,
  parameter int unsigned IDXW  = $clog2(NREGS * XLEN / 8),
  localparam int unsigned RW   = $clog2(NREGS)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            we_i,
  input  logic [RW-1:0]   wreg_i,
  input  logic [IDXW-1:0] widx_i,
  input  logic [1:0]      wkind_i,
  input  logic [XLEN-1:0] wdata_i,
  output logic            werr_o,
  input  logic            re_i,
  input  logic [RW-1:0]   rreg_i,
  input  logic [IDXW-1:0] ridx_i,
  input  logic [1:0]      rkind_i,
  input  logic            rsigned_i,
  output logic            rvalid_o,
  output logic            rerr_o,
  output logic [XLEN-1:0] rdata_o
);
  localparam int unsigned BPR  = XLEN / 8;
  localparam int unsigned OFFW = $clog2(BPR);
  localparam int unsigned SHW  = $clog2(OFFW + 1);

  // write side
  logic [RW-1:0]   w_row;
  logic [OFFW-1:0] w_off;
  logic [SHW-1:0]  w_shift;
  logic            w_err, w_go;
  logic [BPR-1:0]  w_be;
  logic [XLEN-1:0] w_word;

  pkrf_addr #(.XLEN(XLEN), .NREGS(NREGS), .IDXW(IDXW)) u_waddr (
    .reg_i  (wreg_i),
    .idx_i  (widx_i),
    .kind_i (wkind_i),
    .row_o  (w_row),
    .off_o  (w_off),
    .shift_o(w_shift),
    .err_o  (w_err)
  );

  pkrf_lane_write #(.XLEN(XLEN)) u_lane (
    .off_i  (w_off),
    .shift_i(w_shift),
    .data_i (wdata_i),
    .be_o   (w_be),
    .word_o (w_word)
  );

  assign w_go   = we_i & ~w_err;
  assign werr_o = we_i & w_err;

  // read side
  logic [RW-1:0]   r_row;
  logic [OFFW-1:0] r_off;
  logic [SHW-1:0]  r_shift;
  logic            r_err;
  logic [XLEN-1:0] r_word;

  pkrf_addr #(.XLEN(XLEN), .NREGS(NREGS), .IDXW(IDXW)) u_raddr (
    .reg_i  (rreg_i),
    .idx_i  (ridx_i),
    .kind_i (rkind_i),
    .row_o  (r_row),
    .off_o  (r_off),
    .shift_o(r_shift),
    .err_o  (r_err)
  );

  pkrf_bank #(.XLEN(XLEN), .NREGS(NREGS)) u_bank (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (w_go),
    .wrow_i (w_row),
    .be_i   (w_be),
    .wword_i(w_word),
    .re_i   (re_i & ~r_err),
    .rrow_i (r_row),
    .rword_o(r_word)
  );

  logic            rvalid_q, rerr_q, rsigned_q;
  logic [OFFW-1:0] roff_q;
  logic [SHW-1:0]  rshift_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rvalid_q  <= 1'b0;
      rerr_q    <= 1'b0;
      rsigned_q <= 1'b0;
      roff_q    <= '0;
      rshift_q  <= '0;
    end else begin
      rvalid_q <= re_i;
      rerr_q   <= re_i & r_err;
      if (re_i) begin
        rsigned_q <= rsigned_i;
        roff_q    <= r_off;
        rshift_q  <= r_shift;
      end
    end
  end

  pkrf_extract #(.XLEN(XLEN)) u_ext (
    .word_i  (r_word),
    .off_i   (roff_q),
    .shift_i (rshift_q),
    .signed_i(rsigned_q),
    .err_i   (rerr_q),
    .data_o  (rdata_o)
  );

  assign rvalid_o = rvalid_q;
  assign rerr_o   = rerr_q;
endmodule

// File: rtl/pkrf_port_chk.sv
module pkrf_port_chk #(
  parameter int unsigned XLEN = 64
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            we_i,
  input logic            werr_o,
  input logic            re_i,
  input logic [1:0]      rkind_i,
  input logic            rsigned_i,
  input logic            rvalid_o,
  input logic            rerr_o,
  input logic [XLEN-1:0] rdata_o
);
  // R5
  rvalid_after_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    re_i |=> rvalid_o);

  // R5
  rvalid_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !re_i |=> !rvalid_o);

  // R8
  rerr_zero_data_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rerr_o |-> (rvalid_o && rdata_o == '0));

  // R7
  werr_needs_we_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    werr_o |-> we_i);

  // R5
  zext_byte_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (re_i && !rsigned_i && rkind_i == 2'b01) |=> (rdata_o[XLEN-1:8] == '0));

  // R6
  sext_half_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (re_i && rsigned_i && rkind_i == 2'b10) |=>
      ($countones(rdata_o[XLEN-1:15]) == 0 || $countones(rdata_o[XLEN-1:15]) == XLEN - 15));
endmodule

bind pkrf_port pkrf_port_chk #(.XLEN(XLEN)) u_chk (.*);

// File: tb/tb_pkrf_port.sv
`timescale 1ns/1ps
module tb_pkrf_port;
  localparam int XLEN = 64, NREGS = 128, IDXW = 10, NBYTES = NREGS * 8;

  logic clk_i = 1'b0;
  always #2 clk_i = ~clk_i;

  logic            rst_ni, we_i, werr_o, re_i, rsigned_i, rvalid_o, rerr_o;
  logic [6:0]      wreg_i, rreg_i;
  logic [IDXW-1:0] widx_i, ridx_i;
  logic [1:0]      wkind_i, rkind_i;
  logic [XLEN-1:0] wdata_i, rdata_o;

  pkrf_port dut (.*);

  int errors = 0, checks = 0;
  logic [7:0] bm [NBYTES];

  function automatic int esize(logic [1:0] k);
    case (k)
      2'b01: return 1;
      2'b10: return 2;
      2'b11: return 4;
      default: return 8;
    endcase
  endfunction

  function automatic bit oor(int r, int idx, logic [1:0] k);
    return (r * 8 + idx * esize(k)) >= NBYTES;
  endfunction

  function automatic logic [63:0] model_read(int r, int idx, logic [1:0] k, bit sgn);
    logic [63:0] v = '0;
    int a = r * 8 + idx * esize(k);
    int sz = esize(k);
    if (oor(r, idx, k)) return '0;
    for (int b = 0; b < sz; b++) v[b*8 +: 8] = bm[a + b];
    if (sgn && sz < 8 && v[sz*8-1])
      for (int i = sz * 8; i < 64; i++) v[i] = 1'b1;
    return v;
  endfunction

  task automatic model_write(int r, int idx, logic [1:0] k, logic [63:0] d);
    int a = r * 8 + idx * esize(k);
    if (oor(r, idx, k)) return;
    for (int b = 0; b < esize(k); b++) bm[a + b] = d[b*8 +: 8];
  endtask

  task automatic chk(bit ok, string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // entered and left at a falling edge
  task automatic do_write(int r, int idx, logic [1:0] k, logic [63:0] d, string tag);
    bit e = oor(r, idx, k);
    we_i = 1'b1; wreg_i = 7'(r); widx_i = IDXW'(idx); wkind_i = k; wdata_i = d;
    #1;
    chk(werr_o == e, {tag, " werr"}, 64'(werr_o), 64'(e));
    @(negedge clk_i);
    we_i = 1'b0;
    model_write(r, idx, k, d);
  endtask

  task automatic do_read(int r, int idx, logic [1:0] k, bit sgn, string tag);
    logic [63:0] exp = model_read(r, idx, k, sgn);
    bit e = oor(r, idx, k);
    re_i = 1'b1; rreg_i = 7'(r); ridx_i = IDXW'(idx); rkind_i = k; rsigned_i = sgn;
    @(negedge clk_i);
    re_i = 1'b0;
    chk(rvalid_o == 1'b1, {tag, " rvalid"}, 64'(rvalid_o), 64'd1);
    chk(rerr_o == e, {tag, " rerr"}, 64'(rerr_o), 64'(e));
    chk(rdata_o == exp, {tag, " rdata"}, rdata_o, exp);
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    errors++;
    checks++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    for (int i = 0; i < NBYTES; i++) bm[i] = '0;
    rst_ni = 1'b0; we_i = 1'b0; re_i = 1'b0; rsigned_i = 1'b0;
    wreg_i = '0; rreg_i = '0; widx_i = '0; ridx_i = '0;
    wkind_i = '0; rkind_i = '0; wdata_i = '0;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // R10 reset state
    chk(rvalid_o == 1'b0, "R10 rvalid", 64'(rvalid_o), 64'd0);
    chk(rerr_o == 1'b0, "R10 rerr", 64'(rerr_o), 64'd0);
    chk(rdata_o == '0, "R10 rdata", rdata_o, 64'd0);
    do_read(127, 0, 2'b00, 1'b0, "R10 reg127");

    // R2 32-bit element, index 1 occupies upper half of register
    do_write(40, 1, 2'b11, 64'h0000_0000_DEAD_BEEF, "R2");
    do_read(40, 0, 2'b00, 1'b0, "R2 word");
    chk(rdata_o == 64'hDEAD_BEEF_0000_0000, "R2 placement", rdata_o, 64'hDEAD_BEEF_0000_0000);

    // R4 upper data bits ignored; only bytes 6,7 of reg 5 change
    do_write(5, 3, 2'b10, 64'hFFFF_FFFF_FFFF_ABCD, "R4");
    do_read(5, 0, 2'b00, 1'b0, "R4 word");
    chk(rdata_o == 64'hABCD_0000_0000_0000, "R4 only element bytes", rdata_o, 64'hABCD_0000_0000_0000);

    // R1 byte index 9 from reg 10 lands in reg 11 byte 1
    do_write(11, 0, 2'b00, 64'h1111_2222_3333_4444, "R1 prefill");
    do_write(10, 9, 2'b01, 64'h0000_0000_0000_00A5, "R1 cross");
    do_read(11, 0, 2'b00, 1'b0, "R1 word");
    chk(rdata_o == 64'h1111_2222_3333_A544, "R1 cross register", rdata_o, 64'h1111_2222_3333_A544);
    do_read(10, 0, 2'b00, 1'b0, "R3 base untouched");

    // R1 last in-range 32-bit element of the whole file
    do_write(0, 255, 2'b11, 64'h0000_0000_CAFE_F00D, "R1 top");
    do_read(127, 0, 2'b00, 1'b0, "R1 top word");
    chk(rdata_o == 64'hCAFE_F00D_0000_0000, "R1 top placement", rdata_o, 64'hCAFE_F00D_0000_0000);

    // R7 out-of-range writes are flagged and dropped
    do_write(0, 256, 2'b11, 64'hFFFF_FFFF_FFFF_FFFF, "R7 word oor");
    do_write(127, 1, 2'b00, 64'hFFFF_FFFF_FFFF_FFFF, "R7 full oor");
    do_write(1, 1023, 2'b01, 64'hFF, "R7 byte oor");
    do_read(127, 0, 2'b00, 1'b0, "R7 no change");
    chk(rdata_o == 64'hCAFE_F00D_0000_0000, "R7 file intact", rdata_o, 64'hCAFE_F00D_0000_0000);

    // R8 out-of-range read
    do_read(100, 200, 2'b11, 1'b1, "R8");

    // R6 sign extension
    do_write(3, 2, 2'b01, 64'h80, "R6 prefill");
    do_read(3, 2, 2'b01, 1'b1, "R6 signed byte");
    chk(rdata_o == 64'hFFFF_FFFF_FFFF_FF80, "R6 sext", rdata_o, 64'hFFFF_FFFF_FFFF_FF80);
    do_read(3, 2, 2'b01, 1'b0, "R5 unsigned byte");
    chk(rdata_o == 64'h80, "R5 zext", rdata_o, 64'h80);
    do_write(6, 0, 2'b00, 64'h8000_0000_0000_0001, "R6 full prefill");
    do_read(6, 0, 2'b00, 1'b1, "R6 full signed");
    chk(rdata_o == 64'h8000_0000_0000_0001, "R6 full same", rdata_o, 64'h8000_0000_0000_0001);

    // R9 read before write in the same cycle
    do_write(20, 0, 2'b00, 64'h1111_1111_1111_1111, "R9 prefill");
    we_i = 1'b1; wreg_i = 7'd20; widx_i = '0; wkind_i = 2'b00; wdata_i = 64'h2222_2222_2222_2222;
    re_i = 1'b1; rreg_i = 7'd20; ridx_i = '0; rkind_i = 2'b00; rsigned_i = 1'b0;
    @(negedge clk_i);
    we_i = 1'b0; re_i = 1'b0;
    chk(rdata_o == 64'h1111_1111_1111_1111, "R9 old data", rdata_o, 64'h1111_1111_1111_1111);
    model_write(20, 0, 2'b00, 64'h2222_2222_2222_2222);
    do_read(20, 0, 2'b00, 1'b0, "R9 new data");

    // random mix: R1 R2 R3 R5 R6 R7 R8
    for (int n = 0; n < 2500; n++) begin
      int r = int'($urandom_range(0, 127));
      logic [1:0] k = 2'($urandom_range(0, 3));
      int idx = ($urandom_range(0, 9) == 0) ? int'($urandom_range(0, 1023)) : int'($urandom_range(0, 15));
      if ($urandom_range(0, 1) == 0)
        do_write(r, idx, k, {$urandom, $urandom}, "R3 random write");
      else
        do_read(r, idx, k, 1'($urandom_range(0, 1)), "R5 random read");
    end

    // R3 sweep: every byte of the file matches the model
    for (int r = 0; r < NREGS; r++) do_read(r, 0, 2'b00, 1'b0, "R3 sweep");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule